// File: doc/BRIEF.md
# Single-Wire Bus Pulse-Width Capture/Compare Timer

This block gives software the timing help it needs to run a single-wire, bit-banged bus. A free-running timer advances once per tick of a 5 MHz timebase. The tick is a one-cycle enable that a divider makes from the system clock. Each falling edge on the bus input copies the running count into a capture register. Software subtracts two captures to get a pulse width in ticks, then sorts the pulse as sync, 0 or 1.

For transmit, software drives the line through two write-only strobes: one drives the line high and the other drives it low. A compare register is checked against every new capture. When the compare function is enabled and a capture equals the programmed value, a sticky status bit is set and the interrupt line rises. Software clears the bit by writing 1 to it.

The register bus is a plain address/write-enable/data port with a read path that is combinational from the address. There are seven register addresses. Address 0 is control; its bit 5 enables the compare. Address 1 is status, with a write-1-to-clear hit bit in bit 0. Address 2 is the timer (read-only), 3 is the capture register (read-only) and 4 is compare (read/write). A write to address 5 drives the line high and a write to address 6 drives it low; a read of either returns the driven level in bit 0.

Top module: `swbus_pulse_timer`

## Requirements
- R1: The 16-bit timer (read at address 2) advances by exactly one every TICK_DIV system clocks (TICK_DIV of 2 or more), so reads taken M*TICK_DIV cycles apart differ by M.
- R2: The timer wraps from 0xFFFF to 0x0000 and sets no flag: after a wrap, status (address 1) still reads 0 and irq stays low.
- R3: The bus input passes through a two-flop synchronizer. Each falling edge loads the timer into the capture register (address 3) once, so two falls N*TICK_DIV cycles apart give captures that differ by N modulo 2^16. Rising edges and steady levels leave the capture unchanged.
- R4: After reset: control, status, capture and compare read 0x0000, irq is 0 and bus_drv is 1.
- R5: The compare register (address 4) reads back the full 16-bit value last written.
- R6: With control bit 5 set, a capture whose value equals the compare register sets status bit 0 and raises irq.
- R7: With control bit 5 clear, a matching capture leaves status bit 0 and irq at 0.
- R8: Status bit 0 is sticky. Writing 1 to bit 0 of address 1 clears it, and writing 0 leaves it set. Once cleared it stays 0 until a later capture matches again; a non-matching capture does not set it.
- R9: Any write to address 5 drives bus_drv to 1 and any write to address 6 drives it to 0. Reads of either address return bus_drv in bit 0.
- R10: The capture register is read-only: a write to address 3 leaves its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| bus_in | input | 1 | Bus line as received, asynchronous |
| bus_drv | output | 1 | Level driven onto the bus line |
| irq | output | 1 | Compare-match interrupt (sticky status bit 0) |

## Verification
The hardest state to reach is a capture whose value matches the compare register, because the absolute count at any edge is unknown to the bench. The stimulus first makes one falling edge and reads that capture. It then programs the compare to that value plus a chosen width and drops the line again exactly that many ticks later, counting system cycles from the first fall. The timer wrap is reached the same way, with two falls slightly more than 65536 ticks apart.

// File: rtl/swpt_pkg.sv
package swpt_pkg;
  localparam int unsigned TMR_W  = 16;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTRL_CMPEN_BIT = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_TIMER  = 3'd2,
    A_CAPT   = 3'd3,
    A_CMP    = 3'd4,
    A_DRV_HI = 3'd5,
    A_DRV_LO = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/swpt_tick_gen.sv
module swpt_tick_gen #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned DW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DW-1:0] cnt_q, cnt_d;
  logic          at_end;

  always_comb begin
    at_end = (cnt_q == DW'(DIV - 1));
    cnt_d  = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = at_end;

  // R1: ticks are isolated one-cycle enables
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/swpt_fall_det.sv
module swpt_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fall_o
);
  // [0],[1]: synchronizer; [2]: previous synchronized level
  logic [2:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[1:0], line_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 3'b111;
    else        sh_q <= sh_d;
  end

  assign fall_o = sh_q[2] & ~sh_q[1];

  // R3: one capture pulse per edge
  p_one_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/swpt_capcmp.sv
module swpt_capcmp #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         fall_i,
  input  logic         cmp_en_i,
  input  logic [W-1:0] cmp_val_i,
  input  logic         hit_clr_i,
  output logic [W-1:0] timer_o,
  output logic [W-1:0] cap_o,
  output logic         hit_o
);
  logic [W-1:0] timer_q, timer_d;
  logic [W-1:0] cap_q, cap_d;
  logic         hit_q, hit_d, match;

  always_comb begin
    timer_d = tick_i ? timer_q + W'(1) : timer_q;
    cap_d   = fall_i ? timer_q : cap_q;
    match   = fall_i & cmp_en_i & (timer_q == cmp_val_i);
    hit_d   = match | (hit_q & ~hit_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      cap_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      timer_q <= timer_d;
      cap_q   <= cap_d;
      hit_q   <= hit_d;
    end
  end

  assign timer_o = timer_q;
  assign cap_o   = cap_q;
  assign hit_o   = hit_q;

  p_timer_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(timer_q));
  p_cap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_i |=> $stable(cap_q));
  p_hit_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> $past(fall_i && cmp_en_i));
  p_hit_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !hit_clr_i) |=> hit_q);
endmodule

// File: rtl/swbus_pulse_timer.sv
module swbus_pulse_timer
  import swpt_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [TMR_W-1:0]  reg_wdata,
  output logic [TMR_W-1:0]  reg_rdata,
  input  logic              bus_in,
  output logic              bus_drv,
  output logic              irq
);
  logic             tick, fall, hit, hit_clr;
  logic [TMR_W-1:0] timer_v, cap_v;
  logic             cmp_en_q, cmp_en_d;
  logic [TMR_W-1:0] cmp_q, cmp_d;
  logic             drv_q, drv_d;

  swpt_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  swpt_fall_det u_fall (
    .clk(clk), .rst_n(rst_n), .line_i(bus_in), .fall_o(fall));

  swpt_capcmp #(.W(TMR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .fall_i(fall),
    .cmp_en_i(cmp_en_q), .cmp_val_i(cmp_q), .hit_clr_i(hit_clr),
    .timer_o(timer_v), .cap_o(cap_v), .hit_o(hit));

  always_comb begin
    cmp_en_d = cmp_en_q;
    cmp_d    = cmp_q;
    drv_d    = drv_q;
    hit_clr  = 1'b0;
    if (reg_we) begin
      case (reg_addr)
        A_CTRL:   cmp_en_d = reg_wdata[CTRL_CMPEN_BIT];
        A_STAT:   hit_clr  = reg_wdata[0];
        A_CMP:    cmp_d    = reg_wdata;
        A_DRV_HI: drv_d    = 1'b1;
        A_DRV_LO: drv_d    = 1'b0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_en_q <= 1'b0;
      cmp_q    <= '0;
      drv_q    <= 1'b1;
    end else begin
      cmp_en_q <= cmp_en_d;
      cmp_q    <= cmp_d;
      drv_q    <= drv_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata[CTRL_CMPEN_BIT] = cmp_en_q;
      A_STAT:   reg_rdata[0] = hit;
      A_TIMER:  reg_rdata = timer_v;
      A_CAPT:   reg_rdata = cap_v;
      A_CMP:    reg_rdata = cmp_q;
      A_DRV_HI,
      A_DRV_LO: reg_rdata[0] = drv_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign bus_drv = drv_q;
  assign irq     = hit;

  p_drive_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DRV_HI) |=> bus_drv);
  p_drive_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DRV_LO) |=> !bus_drv);
  p_no_hit_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en_q && !irq) |=> !irq);
endmodule

// File: tb/swbus_pulse_timer_tb.sv
module swbus_pulse_timer_tb;
  import swpt_pkg::*;

  localparam int unsigned DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  reg_addr;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        bus_in;
  logic        bus_drv;
  logic        irq;

  int unsigned cyc = 0;
  int unsigned checks = 0;
  int unsigned errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  swbus_pulse_timer #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_in(bus_in),
    .bus_drv(bus_drv), .irq(irq));

  function automatic logic [15:0] exp_width(int unsigned n_cycles);
    return 16'(n_cycles / DIV);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(reg_addr_e a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(reg_addr_e a, logic [15:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  // raise the line, then drop it exactly when cyc reaches tgt
  task automatic fall_at(int unsigned tgt);
    while (cyc < tgt - 3) @(negedge clk);
    bus_in = 1'b1;
    while (cyc < tgt) @(negedge clk);
    bus_in = 1'b0;
  endtask

  task automatic release_bus();
    bus_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic measure(int unsigned k, output logic [15:0] c0,
                         output logic [15:0] c1);
    int unsigned a;
    bus_in = 1'b0;
    a = cyc;
    repeat (4) @(negedge clk);
    rd(A_CAPT, c0);
    fall_at(a + k * DIV);
    repeat (4) @(negedge clk);
    rd(A_CAPT, c1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, c0, c1, t0;
    int unsigned a;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; bus_in = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    rd(A_CTRL, v); chk("R4 ctrl", v, 16'h0000);
    rd(A_STAT, v); chk("R4 stat", v, 16'h0000);
    rd(A_CAPT, v); chk("R4 capture", v, 16'h0000);
    rd(A_CMP,  v); chk("R4 compare", v, 16'h0000);
    chk("R4 irq", {15'b0, irq}, 16'h0000);
    chk("R4 bus_drv", {15'b0, bus_drv}, 16'h0001);

    // R1 timer rate
    @(negedge clk);
    rd(A_TIMER, t0);
    repeat (100 * DIV) @(negedge clk);
    rd(A_TIMER, v);
    chk("R1 timer step", v - t0, 16'd100);

    // R5 compare read/write
    wr(A_CMP, 16'hA5C3);
    rd(A_CMP, v); chk("R5 compare readback", v, 16'hA5C3);

    // R9 drive strobes
    wr(A_DRV_LO, 16'h0000);
    chk("R9 drive low", {15'b0, bus_drv}, 16'h0000);
    rd(A_DRV_HI, v); chk("R9 level read", v, 16'h0000);
    wr(A_DRV_HI, 16'h0000);
    chk("R9 drive high", {15'b0, bus_drv}, 16'h0001);
    rd(A_DRV_LO, v); chk("R9 level read", v, 16'h0001);

    // R3 directed and random widths
    measure(10, c0, c1);
    chk("R3 width 10", c1 - c0, exp_width(10 * DIV));
    release_bus();
    rd(A_CAPT, v); chk("R3 rising edge ignored", v, c1);
    for (int i = 0; i < 20; i++) begin
      int unsigned k;
      k = $urandom_range(600, 6);
      measure(k, c0, c1);
      chk("R3 random width", c1 - c0, exp_width(k * DIV));
      release_bus();
    end

    // R10 capture read-only
    rd(A_CAPT, c0);
    wr(A_CAPT, ~c0);
    rd(A_CAPT, v); chk("R10 capture write ignored", v, c0);

    // R2 wrap across 65536 ticks
    measure(65536 + 9, c0, c1);
    chk("R2 wrapped width", c1 - c0, 16'd9);
    rd(A_STAT, v); chk("R2 no wrap flag", v, 16'h0000);
    chk("R2 irq low", {15'b0, irq}, 16'h0000);
    release_bus();

    // R7 match with compare disabled
    bus_in = 1'b0; a = cyc;
    repeat (4) @(negedge clk);
    rd(A_CAPT, c0);
    wr(A_CMP, c0 + 16'd40);
    fall_at(a + 40 * DIV);
    repeat (4) @(negedge clk);
    rd(A_STAT, v); chk("R7 stat stays 0", v, 16'h0000);
    chk("R7 irq stays low", {15'b0, irq}, 16'h0000);
    release_bus();

    // R6 match with compare enabled
    wr(A_CTRL, 16'h0020);
    rd(A_CTRL, v); chk("R6 enable bit 5", v, 16'h0020);
    bus_in = 1'b0; a = cyc;
    repeat (4) @(negedge clk);
    rd(A_CAPT, c0);
    wr(A_CMP, c0 + 16'd50);
    fall_at(a + 50 * DIV);
    repeat (4) @(negedge clk);
    chk("R6 irq on match", {15'b0, irq}, 16'h0001);
    rd(A_STAT, v); chk("R6 status bit 0", v, 16'h0001);
    release_bus();

    // R8 write-0 keeps, write-1 clears, stays clear
    wr(A_STAT, 16'h0000);
    chk("R8 write 0 keeps", {15'b0, irq}, 16'h0001);
    wr(A_STAT, 16'h0001);
    chk("R8 write 1 clears", {15'b0, irq}, 16'h0000);
    repeat (50) @(negedge clk);
    chk("R8 stays clear", {15'b0, irq}, 16'h0000);
    bus_in = 1'b0; a = cyc;
    repeat (4) @(negedge clk);
    rd(A_CAPT, c0);
    wr(A_CMP, c0 + 16'd31);
    fall_at(a + 30 * DIV);
    repeat (4) @(negedge clk);
    chk("R8 no set on mismatch", {15'b0, irq}, 16'h0000);
    release_bus();
    bus_in = 1'b0; a = cyc;
    repeat (4) @(negedge clk);
    rd(A_CAPT, c0);
    wr(A_CMP, c0 + 16'd25);
    fall_at(a + 25 * DIV);
    repeat (4) @(negedge clk);
    chk("R8 sets again on new match", {15'b0, irq}, 16'h0001);
    release_bus();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule